// File: doc/BRIEF.md
# Clock Failure Detect and Failover

This block guards the main clock of a chip. It runs from the free-running on-chip oscillator, which also clocks its register bus, and it samples the main clock as data. A two-flop synchronizer feeds a rising-edge detector. Edges are counted over fixed windows of reference cycles. When a window sees too few edges, the main clock is declared stopped. When a later window sees enough edges again, the clock is declared restarted.

Software controls the block through one 8-bit register, reached over a plain synchronous bus. Detection can be enabled or disabled. Each enabled event ends in one of two actions: a one-cycle reset request to the system reset controller, or a sticky event flag with an interrupt. In interrupt mode, while the CPU runs from the main clock, a detected stop also moves the CPU clock source over to the on-chip oscillator. It does not do this while the CPU runs from the PLL.

The register holds these fields:
- bit 0, detect enable
- bit 1, oscillator select
- bit 2, event flag
- bit 3, live stopped status
- bit 7, action select

Bits 6 to 4 read as zero.

A write-protect enable input gates all writes. A clock-change lock input freezes the detect enable bit.

Top module: `clk_guard`

## Requirements
- R1: A register write (bus_we=1 with bus_addr equal to REG_ADDR) takes effect only while wr_unlock=1. Other writes change nothing. Reading any other address returns 0.
- R2: Bit 0 is the detect enable. While clk_lock=1, a write leaves bit 0 unchanged and still updates the other writable bits.
- R3: With bit 7=0, a stop detected while bit 0=1 produces an osc_rst_req pulse exactly one cycle long and no irq_req. A restart never produces osc_rst_req.
- R4: Bit 2 is set by any stop or restart detected while bit 0=1. Writing 0 to bit 2 clears it. Writing 1 leaves it unchanged. irq_req does not clear it.
- R5: With bit 7=1, irq_req is a one-cycle pulse that is issued only when bit 2 goes from 0 to 1. An event detected while bit 2 is already 1 gives no interrupt.
- R6: Bit 3 is read-only and always live, independent of bit 0. It reads 1 (stopped) after a 16-cycle window counts fewer than 2 synchronized rising edges of main_clk. It reads 0 again after a later window counts 2 or more.
- R7: With bit 0=1, bit 7=1 and src_is_pll=0, a detected stop sets bit 1. clk_sel_osc always equals bit 1.
- R8: With src_is_pll=1, a detected stop leaves bit 1 unchanged. The flag and the interrupt still follow R4 and R5.
- R9: A one-cycle fail_rst pulse keeps bits 0, 1 and 7 and clears bit 2.
- R10: Power-on reset (rst_n=0) clears the whole register and all outputs. Bits 6 to 4 read 0 and ignore writes.
- R11: With bit 0=0, stop and restart events produce no flag, no irq_req, no osc_rst_req and no source change, though bit 3 still tracks the clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | On-chip oscillator, reference and bus clock |
| rst_n | input | 1 | Power-on reset, active low |
| fail_rst | input | 1 | Oscillation-stop reset from the reset controller, one cycle |
| main_clk | input | 1 | Monitored main clock, asynchronous |
| bus_addr | input | ADDR_W | Register address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from bus_addr |
| wr_unlock | input | 1 | Write-protect enable, 1 permits writes |
| clk_lock | input | 1 | Clock-change lock, 1 freezes bit 0 |
| src_is_pll | input | 1 | CPU currently clocked from the PLL |
| irq_req | output | 1 | Interrupt request pulse |
| osc_rst_req | output | 1 | Reset request pulse |
| clk_sel_osc | output | 1 | CPU clock source select, 1 selects the on-chip oscillator |

## Verification
The hardest situations to reach are those that need a second event to arrive while the flag is still set. One is a restart after an unacknowledged stop. The other is a stop seen while the PLL is the clock source. Each needs the main clock to be gated off and then back on for several full windows, in a fixed order relative to flag writes and mode changes. The bench holds its main-clock generator idle long enough for two windows plus synchronizer delay, then restarts it. It runs this sequence in interrupt mode from both clock sources, in reset mode with a following fail_rst pulse, and with detection off. Seeded random register traffic under random protect and lock settings covers the write-side rules.

// File: rtl/clk_guard_pkg.sv
package clk_guard_pkg;
  localparam int REG_W   = 8;
  localparam int B_DET   = 0;
  localparam int B_OSC   = 1;
  localparam int B_FLAG  = 2;
  localparam int B_STOP  = 3;
  localparam int B_ACT   = 7;

  typedef struct packed {
    logic act_irq;
    logic stopped;
    logic flag;
    logic use_osc;
    logic det_en;
  } guard_reg_t;

  function automatic logic [REG_W-1:0] pack_reg(guard_reg_t r);
    logic [REG_W-1:0] v;
    v         = '0;
    v[B_DET]  = r.det_en;
    v[B_OSC]  = r.use_osc;
    v[B_FLAG] = r.flag;
    v[B_STOP] = r.stopped;
    v[B_ACT]  = r.act_irq;
    return v;
  endfunction
endpackage

// File: rtl/clk_guard_sync.sv
module clk_guard_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise_o
);
  logic [STAGES:0] sh_q;

  genvar g;
  generate
    for (g = 0; g <= STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sh_q[0] <= 1'b0;
          else        sh_q[0] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sh_q[g] <= 1'b0;
          else        sh_q[g] <= sh_q[g-1];
        end
      end
    end
  endgenerate

  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/clk_guard_window.sv
module clk_guard_window #(
  parameter int WIN_LEN   = 16,
  parameter int MIN_EDGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rise_i,
  output logic stopped_o,
  output logic stop_ev_o,
  output logic restart_ev_o
);
  localparam int CW = (WIN_LEN > 1) ? $clog2(WIN_LEN) : 1;
  localparam int EW = $clog2(MIN_EDGES + 1);
  localparam logic [CW-1:0] LAST = CW'(WIN_LEN - 1);
  localparam logic [EW-1:0] SAT  = EW'(MIN_EDGES);

  logic [CW-1:0] win_q;
  logic [EW-1:0] edges_q, edges_nxt;
  logic          win_end, enough;

  assign win_end   = (win_q == LAST);
  assign edges_nxt = (edges_q == SAT) ? edges_q : edges_q + EW'(rise_i);
  assign enough    = (edges_nxt >= SAT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q        <= '0;
      edges_q      <= '0;
      stopped_o    <= 1'b0;
      stop_ev_o    <= 1'b0;
      restart_ev_o <= 1'b0;
    end else begin
      stop_ev_o    <= 1'b0;
      restart_ev_o <= 1'b0;
      if (win_end) begin
        win_q   <= '0;
        edges_q <= '0;
        if (stopped_o && enough) begin
          stopped_o    <= 1'b0;
          restart_ev_o <= 1'b1;
        end else if (!stopped_o && !enough) begin
          stopped_o <= 1'b1;
          stop_ev_o <= 1'b1;
        end
      end else begin
        win_q   <= win_q + 1'b1;
        edges_q <= edges_nxt;
      end
    end
  end
endmodule

// File: rtl/clk_guard_regs.sv
module clk_guard_regs (
  input  logic clk,
  input  logic rst_n,
  input  logic fail_rst,
  input  logic wr_i,
  input  logic wd_det,
  input  logic wd_osc,
  input  logic wd_flag,
  input  logic wd_act,
  input  logic clk_lock,
  input  logic src_is_pll,
  input  logic stop_ev,
  input  logic restart_ev,
  output logic det_en,
  output logic use_osc,
  output logic flag,
  output logic act_irq,
  output logic irq_o,
  output logic rst_req_o
);
  logic ev;
  assign ev = det_en & (stop_ev | restart_ev);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      det_en    <= 1'b0;
      use_osc   <= 1'b0;
      flag      <= 1'b0;
      act_irq   <= 1'b0;
      irq_o     <= 1'b0;
      rst_req_o <= 1'b0;
    end else begin
      irq_o     <= 1'b0;
      rst_req_o <= 1'b0;
      if (fail_rst) begin
        flag <= 1'b0;
      end else begin
        if (wr_i) begin
          if (!clk_lock) det_en <= wd_det;
          use_osc <= wd_osc;
          act_irq <= wd_act;
          if (!wd_flag) flag <= 1'b0;
        end
        if (ev) begin
          flag <= 1'b1;
          if (act_irq && !flag) irq_o <= 1'b1;
          if (stop_ev && !act_irq) rst_req_o <= 1'b1;
          if (stop_ev && act_irq && !src_is_pll) use_osc <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/clk_guard.sv
module clk_guard
  import clk_guard_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int REG_ADDR    = 12,
  parameter int SYNC_STAGES = 2,
  parameter int WIN_LEN     = 16,
  parameter int MIN_EDGES   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fail_rst,
  input  logic              main_clk,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              wr_unlock,
  input  logic              clk_lock,
  input  logic              src_is_pll,
  output logic              irq_req,
  output logic              osc_rst_req,
  output logic              clk_sel_osc
);
  localparam logic [ADDR_W-1:0] HIT_ADDR = ADDR_W'(REG_ADDR);

  logic rise, stopped, stop_ev, restart_ev;
  logic hit, wr;
  logic det_en, use_osc, flag, act_irq;
  logic wdata_unused;
  guard_reg_t view;

  assign wdata_unused = ^bus_wdata[6:3];
  assign hit = (bus_addr == HIT_ADDR);
  assign wr  = bus_we & wr_unlock & hit;

  clk_guard_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(main_clk), .rise_o(rise)
  );

  clk_guard_window #(.WIN_LEN(WIN_LEN), .MIN_EDGES(MIN_EDGES)) u_win (
    .clk(clk), .rst_n(rst_n), .rise_i(rise),
    .stopped_o(stopped), .stop_ev_o(stop_ev), .restart_ev_o(restart_ev)
  );

  clk_guard_regs u_regs (
    .clk(clk), .rst_n(rst_n), .fail_rst(fail_rst), .wr_i(wr),
    .wd_det(bus_wdata[B_DET]), .wd_osc(bus_wdata[B_OSC]),
    .wd_flag(bus_wdata[B_FLAG]), .wd_act(bus_wdata[B_ACT]),
    .clk_lock(clk_lock), .src_is_pll(src_is_pll),
    .stop_ev(stop_ev), .restart_ev(restart_ev),
    .det_en(det_en), .use_osc(use_osc), .flag(flag), .act_irq(act_irq),
    .irq_o(irq_req), .rst_req_o(osc_rst_req)
  );

  assign view = '{act_irq: act_irq, stopped: stopped, flag: flag,
                  use_osc: use_osc, det_en: det_en};
  assign bus_rdata   = hit ? pack_reg(view) : 8'h00;
  assign clk_sel_osc = use_osc;
endmodule

// File: rtl/clk_guard_chk.sv
module clk_guard_chk #(
  parameter int ADDR_W   = 4,
  parameter int REG_ADDR = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fail_rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic [7:0]        bus_rdata,
  input logic              wr_unlock,
  input logic              clk_lock,
  input logic              src_is_pll,
  input logic              irq_req,
  input logic              osc_rst_req,
  input logic              det_en,
  input logic              use_osc,
  input logic              flag,
  input logic              act_irq
);
  logic hit;
  assign hit = (bus_addr == ADDR_W'(REG_ADDR));

  p_protect_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && !wr_unlock && !fail_rst) |=> ($stable(det_en) && $stable(act_irq)));

  p_lock_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && wr_unlock && hit && clk_lock) |=> $stable(det_en));

  p_rst_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    osc_rst_req |=> !osc_rst_req);

  p_rst_no_irq_r3: assert property (@(posedge clk) disable iff (!rst_n)
    osc_rst_req |-> !irq_req);

  p_irq_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (flag && !$past(flag)));

  p_pll_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (src_is_pll && !use_osc && !(bus_we && wr_unlock && hit)) |=> !use_osc);

  p_fail_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fail_rst |=> ($stable(det_en) && $stable(use_osc) && $stable(act_irq) && !flag));

  p_zero_bits_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[6:4] == 3'b000);

  p_disabled_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !det_en |=> (!irq_req && !osc_rst_req));
endmodule

bind clk_guard clk_guard_chk #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_chk (
  .clk(clk), .rst_n(rst_n), .fail_rst(fail_rst), .bus_addr(bus_addr),
  .bus_we(bus_we), .bus_rdata(bus_rdata), .wr_unlock(wr_unlock),
  .clk_lock(clk_lock), .src_is_pll(src_is_pll), .irq_req(irq_req),
  .osc_rst_req(osc_rst_req), .det_en(det_en), .use_osc(use_osc),
  .flag(flag), .act_irq(act_irq)
);

// File: tb/clk_guard_bench.sv
module clk_guard_bench;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 4;
  localparam int REG_ADDR   = 12;
  localparam int SETTLE     = 60;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fail_rst = 1'b0;
  logic main_clk = 1'b0;
  logic [ADDR_W-1:0] bus_addr = ADDR_W'(REG_ADDR);
  logic bus_we = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic wr_unlock = 1'b1;
  logic clk_lock = 1'b0;
  logic src_is_pll = 1'b0;
  logic irq_req, osc_rst_req, clk_sel_osc;

  logic mc_run = 1'b1;
  int n_chk = 0, n_fail = 0, irq_cnt = 0, rst_cnt = 0;
  bit done = 1'b0;

  clk_guard #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_clk_guard (
    .clk(clk), .rst_n(rst_n), .fail_rst(fail_rst), .main_clk(main_clk),
    .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .wr_unlock(wr_unlock), .clk_lock(clk_lock),
    .src_is_pll(src_is_pll), .irq_req(irq_req), .osc_rst_req(osc_rst_req),
    .clk_sel_osc(clk_sel_osc)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    #3;
    forever begin
      if (mc_run) begin #(2*CLK_PERIOD); main_clk = ~main_clk; end
      else #(CLK_PERIOD);
    end
  end

  always @(negedge clk) begin
    if (irq_req) irq_cnt++;
    if (osc_rst_req) rst_cnt++;
  end

  // Expected register after an accepted write (R1, R2, R4, R10)
  function automatic logic [7:0] model_wr(logic [7:0] old, logic [7:0] wd, logic lock);
    logic [7:0] n;
    n = old & 8'h8F;
    if (!lock) n[0] = wd[0];
    n[1] = wd[1];
    n[7] = wd[7];
    if (!wd[2]) n[2] = 1'b0;
    return n;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic write(logic [ADDR_W-1:0] a, logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; bus_addr = ADDR_W'(REG_ADDR);
  endtask

  task automatic read_chk(string req, logic [7:0] exp);
    @(negedge clk);
    bus_addr = ADDR_W'(REG_ADDR);
    #1;
    check(req, bus_rdata, exp);
  endtask

  task automatic settle();
    repeat (SETTLE) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    logic [7:0] exp_reg;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    settle();
    // R10: power-on state
    read_chk("R10 reset reg", 8'h00);
    check("R10 reset outs", {irq_cnt[7:0], rst_cnt[7:0], 7'd0, clk_sel_osc}, 0);

    // Random register traffic with the main clock running (R1, R2, R10)
    exp_reg = 8'h00;
    for (int i = 0; i < 200; i++) begin
      logic [7:0] d;
      logic [ADDR_W-1:0] a;
      logic ul, lk;
      d  = 8'($urandom);
      a  = ($urandom % 4 == 0) ? ADDR_W'($urandom) : ADDR_W'(REG_ADDR);
      ul = ($urandom % 3 != 0);
      lk = ($urandom % 2 == 0);
      d[0] = 1'b0; // keep detection idle while traffic runs
      @(negedge clk);
      wr_unlock = ul; clk_lock = lk;
      write(a, d);
      if (ul && a == ADDR_W'(REG_ADDR)) exp_reg = model_wr(exp_reg, d, lk);
      read_chk("R1 R2 R10 random write", exp_reg);
      bus_addr = ADDR_W'(REG_ADDR + 1);
      #1;
      check("R1 other address reads 0", bus_rdata, 8'h00);
    end
    wr_unlock = 1'b1; clk_lock = 1'b0;

    // Interrupt mode, CPU on main clock: stop (R5 R6 R7)
    write(ADDR_W'(REG_ADDR), 8'h81);
    irq_cnt = 0; rst_cnt = 0;
    mc_run = 1'b0; settle();
    read_chk("R6 R7 stop detected", 8'h8F);
    check("R5 one irq", irq_cnt, 1);
    check("R7 clk_sel_osc", clk_sel_osc, 1);
    check("R3 no reset in irq mode", rst_cnt, 0);
    write(ADDR_W'(REG_ADDR), 8'h8F);
    read_chk("R4 write 1 keeps flag", 8'h8F);
    mc_run = 1'b1; settle();
    read_chk("R6 R4 restart, flag sticky", 8'h87);
    check("R5 no irq while flag set", irq_cnt, 1);

    // PLL source: no failover (R8)
    write(ADDR_W'(REG_ADDR), 8'h81);
    read_chk("R4 write 0 clears flag", 8'h81);
    src_is_pll = 1'b1;
    mc_run = 1'b0; settle();
    read_chk("R8 bit1 kept on PLL", 8'h8D);
    check("R8 irq still raised", irq_cnt, 2);
    check("R8 clk_sel_osc low", clk_sel_osc, 0);
    mc_run = 1'b1; settle();
    read_chk("R5 restart with flag set", 8'h85);
    check("R5 irq count after restart", irq_cnt, 2);
    src_is_pll = 1'b0;

    // Reset mode (R3, R9)
    write(ADDR_W'(REG_ADDR), 8'h03);
    read_chk("R3 reset mode setup", 8'h03);
    mc_run = 1'b0; settle();
    check("R3 one reset pulse", rst_cnt, 1);
    check("R3 no irq in reset mode", irq_cnt, 2);
    read_chk("R3 R4 flag in reset mode", 8'h0F);
    @(negedge clk); fail_rst = 1'b1;
    @(negedge clk); fail_rst = 1'b0;
    read_chk("R9 bits kept, flag cleared", 8'h0B);
    mc_run = 1'b1; settle();
    check("R3 no reset on restart", rst_cnt, 1);
    read_chk("R4 restart sets flag", 8'h07);

    // Detection disabled (R11)
    write(ADDR_W'(REG_ADDR), 8'h80);
    mc_run = 1'b0; settle();
    read_chk("R11 status only", 8'h88);
    check("R11 no irq", irq_cnt, 2);
    check("R11 no reset", rst_cnt, 1);
    mc_run = 1'b1; settle();
    read_chk("R11 R6 status clears", 8'h80);

    // Directed write corners (R1, R2, R10)
    clk_lock = 1'b1;
    write(ADDR_W'(REG_ADDR), 8'h81);
    read_chk("R2 lock holds bit0", 8'h80);
    clk_lock = 1'b0;
    write(ADDR_W'(REG_ADDR), 8'h81);
    read_chk("R2 unlocked write", 8'h81);
    wr_unlock = 1'b0;
    write(ADDR_W'(REG_ADDR), 8'h00);
    read_chk("R1 protected write ignored", 8'h81);
    wr_unlock = 1'b1;
    write(ADDR_W'(REG_ADDR + 2), 8'h00);
    read_chk("R1 other address write ignored", 8'h81);
    write(ADDR_W'(REG_ADDR), 8'hF1);
    read_chk("R10 bits 6..4 read 0", 8'h81);

    finish_run();
  end
endmodule